// File: doc/BRIEF.md
# Floating-Point Compare Condition Mask Unit

This unit compares two IEEE-754 operands and returns a 32-bit condition mask for a processor's compare instruction. Both operands have the same precision, chosen by a select input: double precision uses all 64 bits of each operand port, and single precision uses only the low 32 bits. The mask carries three groups of bits. The relational bits are equal, less, greater and the predicates built from them. The unordered-aware predicates also hold when either operand is a NaN. The range bits tell whether the first operand `a` lies inside the interval from zero to the second operand `b`.

A one-cycle `start_i` strobe launches a compare. The mask and an invalid-operation flag are captured at the next rising edge, and `done_o` is high for exactly that one cycle. The mask and the flag then hold their values until the next strobe. An unordered-compare mode raises the invalid flag only for signaling NaNs. A legacy mode clears the extended unordered-aware predicates, so the unit matches an older encoding of the mask.

Top module: `fcmp_mask_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `mask_o`, `invalid_o` and `done_o` become zero.
- R2: `start_i` is sampled at a rising edge. At that same edge `mask_o` and `invalid_o` take the result and `done_o` rises. `done_o` is high for exactly one cycle per strobe. `mask_o` and `invalid_o` keep their values while no strobe is sampled.
- R3: An operand is a NaN in the following cases. In single precision, the exponent field (bits 30:23) is all ones and the fraction (bits 22:0) is nonzero. In double precision, the exponent field (bits 62:52) is all ones and the fraction (bits 51:0) is nonzero. If either operand is a NaN, the mask is 0x3D009: bits 0, 3, 12, 14, 15, 16 and 17. Bits 8 to 11 stay clear in this case.
- R4: A signaling NaN is a NaN whose top fraction bit is clear (bit 22 in single precision, bit 51 in double precision). With `ucmp_i`=0, any NaN operand sets `invalid_o`. With `ucmp_i`=1, only a signaling NaN sets it. Operand `a` is examined first: if `a` is a NaN, only `a` decides the flag. Ordered operands never set `invalid_o`.
- R5: Ordered operands produce exactly one relation, each with a fixed relational mask. Equal gives bits 1, 2, 5, 7, 12, 15 and 17, which is 0x290A6. Less gives bits 1, 3, 5, 6, 13, 15 and 16, which is 0x1A06A. Greater gives bits 1, 3, 4, 7, 13, 14 and 17, which is 0x2609A.
- R6: Ordering uses sign and magnitude. Positive zero and negative zero compare equal. Infinities are the largest and smallest values.
- R7: With `legacy_i`=1, mask bits 17:12 are zero and all other bits are unchanged.
- R8: When `b` has its sign bit set, bits 8 to 11 are zero.
- R9: For ordered operands with `b` non-negative, the range bits are set as follows. If `a` equals `b` or `a` is zero of either sign, bits 9 and 11 are set. Otherwise, if `a` is greater than `b`, bits 8 and 11 are set. Otherwise, if `a` is positive, bits 9 and 10 are set. Otherwise, bits 8 and 11 are set.
- R10: Mask bits 31:18 are always zero.
- R11: With `dbl_i`=0, bits 63:32 of both operand ports have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Compare strobe |
| dbl_i | input | 1 | 1 = double precision, 0 = single precision in the low 32 bits |
| ucmp_i | input | 1 | Unordered-compare mode: only signaling NaNs raise the invalid flag |
| legacy_i | input | 1 | Clear mask bits 17:12 |
| opa_i | input | 64 | Operand a |
| opb_i | input | 64 | Operand b, upper bound of the range test |
| mask_o | output | 32 | Registered condition mask |
| done_o | output | 1 | One-cycle result strobe |
| invalid_o | output | 1 | Registered invalid-operation flag |

## Verification
The bench mixes random operands with directed cases. Operand classes are weighted toward zeros, infinities, quiet and signaling NaNs, and operand pairs that are equal or negated copies of each other. The directed cases cover positive zero against negative zero, which a plain bit compare would report as less or greater. They cover a quiet NaN in `a` with a signaling NaN in `b` under unordered-compare mode, where a design that lets `b` decide would raise a false invalid flag. They also cover a negative `b`, where a design with a wrong range test would leak range bits, and a negative `a` against a positive `b`, which must be out of range and not inside it. Single-precision cases put random data in the unused upper 32 bits, so any leak from those bits into the NaN test or the ordering shows up.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    localparam int OP_W   = 64;
    localparam int MAG_W  = OP_W - 1;
    localparam int MASK_W = 32;
    localparam int SP_W   = 32;

    // Mask bit positions (decoded by the consumer of the mask)
    localparam int B_UN  = 0;
    localparam int B_ORD = 1;
    localparam int B_EQ  = 2;
    localparam int B_NE  = 3;
    localparam int B_GT  = 4;
    localparam int B_LE  = 5;
    localparam int B_LT  = 6;
    localparam int B_GE  = 7;
    localparam int B_OUT = 8;
    localparam int B_INB = 9;
    localparam int B_IN  = 10;
    localparam int B_OUB = 11;
    localparam int B_UE  = 12;
    localparam int B_LG  = 13;
    localparam int B_UG  = 14;
    localparam int B_ULE = 15;
    localparam int B_UL  = 16;
    localparam int B_UGE = 17;
    localparam int EXT_LO = B_UE;
    localparam int EXT_HI = B_UGE;

    typedef enum logic [1:0] {
        REL_EQ = 2'd0,
        REL_LT = 2'd1,
        REL_GT = 2'd2
    } rel_e;

    typedef struct packed {
        logic             sign;
        logic [MAG_W-1:0] mag;
        logic             zero;
        logic             nan;
        logic             snan;
    } fp_info_t;

    // Single-precision NaN test: value shifted left by one exceeds 0xFF000000
    function automatic logic sp_is_nan(input logic [SP_W-1:0] v);
        return {v[SP_W-2:0], 1'b0} > 32'hFF00_0000;
    endfunction

    function automatic logic sp_is_snan(input logic [SP_W-1:0] v);
        return (v[30:22] == 9'h1FE) && (|v[21:0]);
    endfunction

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
    import fcmp_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    input  logic            dbl_i,
    output fp_info_t        info_o
);
    localparam int DP_EXP_HI = OP_W - 2;
    localparam int DP_EXP_LO = 52;
    localparam int DP_QBIT   = DP_EXP_LO - 1;

    logic dp_exp_ones;
    logic dp_frac_nz;

    always_comb begin
        dp_exp_ones = &op_i[DP_EXP_HI:DP_EXP_LO];
        dp_frac_nz  = |op_i[DP_QBIT:0];
        info_o      = '0;
        if (dbl_i) begin
            info_o.sign = op_i[OP_W-1];
            info_o.mag  = op_i[MAG_W-1:0];
            info_o.nan  = dp_exp_ones && dp_frac_nz;
            info_o.snan = dp_exp_ones && dp_frac_nz && !op_i[DP_QBIT];
        end else begin
            info_o.sign = op_i[SP_W-1];
            info_o.mag  = {{(MAG_W-SP_W+1){1'b0}}, op_i[SP_W-2:0]};
            info_o.nan  = sp_is_nan(op_i[SP_W-1:0]);
            info_o.snan = sp_is_snan(op_i[SP_W-1:0]);
        end
        info_o.zero = (info_o.mag == '0);
    end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
    import fcmp_pkg::*;
(
    input  logic             a_sign_i,
    input  logic [MAG_W-1:0] a_mag_i,
    input  logic             a_zero_i,
    input  logic             b_sign_i,
    input  logic [MAG_W-1:0] b_mag_i,
    input  logic             b_zero_i,
    output rel_e             rel_o
);
    logic mag_lt;
    logic mag_eq;

    always_comb begin
        mag_lt = a_mag_i < b_mag_i;
        mag_eq = a_mag_i == b_mag_i;
        if (a_zero_i && b_zero_i)
            rel_o = REL_EQ;
        else if (a_sign_i != b_sign_i)
            rel_o = a_sign_i ? REL_LT : REL_GT;
        else if (mag_eq)
            rel_o = REL_EQ;
        else if (mag_lt ^ a_sign_i)
            rel_o = REL_LT;
        else
            rel_o = REL_GT;
    end
endmodule

// File: rtl/fcmp_mask_build.sv
module fcmp_mask_build
    import fcmp_pkg::*;
(
    input  logic              a_nan_i,
    input  logic              a_snan_i,
    input  logic              a_zero_i,
    input  logic              a_sign_i,
    input  logic              b_nan_i,
    input  logic              b_snan_i,
    input  logic              b_sign_i,
    input  rel_e              rel_i,
    input  logic              ucmp_i,
    input  logic              legacy_i,
    output logic [MASK_W-1:0] mask_o,
    output logic              invalid_o
);
    logic [MASK_W-1:0] m;

    always_comb begin
        m         = '0;
        invalid_o = 1'b0;
        if (a_nan_i || b_nan_i) begin
            m[B_UN]  = 1'b1;
            m[B_NE]  = 1'b1;
            m[B_UE]  = 1'b1;
            m[B_UG]  = 1'b1;
            m[B_ULE] = 1'b1;
            m[B_UL]  = 1'b1;
            m[B_UGE] = 1'b1;
            // operand a has priority in deciding the flag
            invalid_o = a_nan_i ? (!ucmp_i || a_snan_i) : (!ucmp_i || b_snan_i);
        end else begin
            m[B_ORD] = 1'b1;
            unique case (rel_i)
                REL_EQ: begin
                    m[B_EQ] = 1'b1; m[B_LE] = 1'b1; m[B_GE] = 1'b1;
                    m[B_UE] = 1'b1; m[B_ULE] = 1'b1; m[B_UGE] = 1'b1;
                end
                REL_LT: begin
                    m[B_LT] = 1'b1; m[B_NE] = 1'b1; m[B_LE] = 1'b1;
                    m[B_LG] = 1'b1; m[B_ULE] = 1'b1; m[B_UL] = 1'b1;
                end
                default: begin
                    m[B_GT] = 1'b1; m[B_NE] = 1'b1; m[B_GE] = 1'b1;
                    m[B_LG] = 1'b1; m[B_UG] = 1'b1; m[B_UGE] = 1'b1;
                end
            endcase
            // range test of a against [0, b], only for non-negative b
            if (!b_sign_i) begin
                if (rel_i == REL_EQ || a_zero_i) begin
                    m[B_INB] = 1'b1; m[B_OUB] = 1'b1;
                end else if (rel_i == REL_GT || a_sign_i) begin
                    m[B_OUT] = 1'b1; m[B_OUB] = 1'b1;
                end else begin
                    m[B_INB] = 1'b1; m[B_IN] = 1'b1;
                end
            end
        end
        if (legacy_i)
            m[EXT_HI:EXT_LO] = '0;
        mask_o = m;
    end
endmodule

// File: rtl/fcmp_mask_unit.sv
module fcmp_mask_unit
    import fcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              dbl_i,
    input  logic              ucmp_i,
    input  logic              legacy_i,
    input  logic [OP_W-1:0]   opa_i,
    input  logic [OP_W-1:0]   opb_i,
    output logic [MASK_W-1:0] mask_o,
    output logic              done_o,
    output logic              invalid_o
);
    fp_info_t          info [2];
    rel_e              rel;
    logic [MASK_W-1:0] mask_d;
    logic              inv_d;

    for (genvar g = 0; g < 2; g++) begin : g_cls
        fcmp_classify u_cls (
            .op_i   (g == 0 ? opa_i : opb_i),
            .dbl_i  (dbl_i),
            .info_o (info[g])
        );
    end

    fcmp_order u_ord (
        .a_sign_i (info[0].sign),
        .a_mag_i  (info[0].mag),
        .a_zero_i (info[0].zero),
        .b_sign_i (info[1].sign),
        .b_mag_i  (info[1].mag),
        .b_zero_i (info[1].zero),
        .rel_o    (rel)
    );

    fcmp_mask_build u_bld (
        .a_nan_i   (info[0].nan),
        .a_snan_i  (info[0].snan),
        .a_zero_i  (info[0].zero),
        .a_sign_i  (info[0].sign),
        .b_nan_i   (info[1].nan),
        .b_snan_i  (info[1].snan),
        .b_sign_i  (info[1].sign),
        .rel_i     (rel),
        .ucmp_i    (ucmp_i),
        .legacy_i  (legacy_i),
        .mask_o    (mask_d),
        .invalid_o (inv_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_o    <= '0;
            invalid_o <= 1'b0;
            done_o    <= 1'b0;
        end else begin
            done_o <= start_i;
            if (start_i) begin
                mask_o    <= mask_d;
                invalid_o <= inv_d;
            end
        end
    end

    // R2: results hold while no strobe is sampled
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> $stable(mask_o) && $stable(invalid_o));

    // R5: ordered results carry exactly one of equal, less, greater
    p_one_rel_r5: assert property (@(posedge clk) disable iff (rst)
        done_o && !mask_o[B_UN] |-> $countones({mask_o[B_EQ], mask_o[B_LT], mask_o[B_GT]}) == 1);

    // R3: unordered results carry no range bits and no ordered bit
    p_un_no_range_r3: assert property (@(posedge clk) disable iff (rst)
        done_o && mask_o[B_UN] |-> mask_o[B_OUB:B_OUT] == '0 && !mask_o[B_ORD]);

    // R7: legacy mode clears the extended predicates
    p_legacy_r7: assert property (@(posedge clk) disable iff (rst)
        start_i && legacy_i |=> mask_o[EXT_HI:EXT_LO] == '0);

    // R9: inside and outside never both asserted
    p_range_excl_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !(mask_o[B_OUT] && mask_o[B_INB]) && (!mask_o[B_IN] || mask_o[B_INB]));

    // R10: upper mask bits are unused
    p_upper_zero_r10: assert property (@(posedge clk) disable iff (rst)
        mask_o[MASK_W-1:EXT_HI+1] == '0);

    // R4: ordered operands never raise invalid
    p_inv_ordered_r4: assert property (@(posedge clk) disable iff (rst)
        done_o && !mask_o[B_UN] |-> !invalid_o);
endmodule

// File: tb/test_fcmp_mask_unit.sv
module test_fcmp_mask_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        start_i, dbl_i, ucmp_i, legacy_i;
    logic [63:0] opa_i, opb_i;
    logic [31:0] mask_o;
    logic        done_o, invalid_o;

    int n_chk = 0;
    int n_err = 0;
    bit ended = 0;

    always #2 clk = ~clk;

    fcmp_mask_unit i_fcmp_mask_unit (
        .clk(clk), .rst(rst), .start_i(start_i), .dbl_i(dbl_i),
        .ucmp_i(ucmp_i), .legacy_i(legacy_i), .opa_i(opa_i), .opb_i(opb_i),
        .mask_o(mask_o), .done_o(done_o), .invalid_o(invalid_o)
    );

    localparam logic [31:0] M_EQ = 32'h000290A6;
    localparam logic [31:0] M_LT = 32'h0001A06A;
    localparam logic [31:0] M_GT = 32'h0002609A;
    localparam logic [31:0] M_UN = 32'h0003D009;

    function automatic void unpack(input logic [63:0] v, input logic dbl,
                                   output logic s, output logic [62:0] mg,
                                   output logic n, output logic sn);
        if (dbl) begin
            s  = v[63];
            mg = v[62:0];
            n  = (v[62:52] == 11'h7FF) && (v[51:0] != 0);
            sn = n && (v[51] == 1'b0);
        end else begin
            s  = v[31];
            mg = {32'd0, v[30:0]};
            n  = (v[30:23] == 8'hFF) && (v[22:0] != 0);
            sn = n && (v[22] == 1'b0);
        end
    endfunction

    function automatic void model(input logic [63:0] a, input logic [63:0] b,
                                  input logic dbl, input logic uc, input logic lg,
                                  output logic [31:0] m, output logic inv);
        logic sa, sb, na, nb, ssa, ssb;
        logic [62:0] ma, mb;
        longint ka, kb;
        unpack(a, dbl, sa, ma, na, ssa);
        unpack(b, dbl, sb, mb, nb, ssb);
        inv = 1'b0;
        if (na) begin
            m = M_UN; inv = !uc || ssa;
        end else if (nb) begin
            m = M_UN; inv = !uc || ssb;
        end else begin
            ka = sa ? -longint'({1'b0, ma}) : longint'({1'b0, ma});
            kb = sb ? -longint'({1'b0, mb}) : longint'({1'b0, mb});
            if (ka == kb)      m = M_EQ;
            else if (ka < kb)  m = M_LT;
            else               m = M_GT;
            if (!sb) begin
                if (ka == kb || ka == 0) m |= 32'h00000A00;
                else if (ka > kb)        m |= 32'h00000900;
                else if (ka > 0)         m |= 32'h00000600;
                else                     m |= 32'h00000900;
            end
        end
        if (lg) m &= 32'hFFFC0FFF;
    endfunction

    task automatic check(input string tag, input logic [31:0] m_got, input logic [31:0] m_exp,
                         input logic i_got, input logic i_exp, input logic d_got, input logic d_exp);
        n_chk++;
        if (m_got !== m_exp || i_got !== i_exp || d_got !== d_exp) begin
            n_err++;
            $display("FAIL %s: mask=%h inv=%b done=%b expected mask=%h inv=%b done=%b",
                     tag, m_got, i_got, d_got, m_exp, i_exp, d_exp);
        end
    endtask

    // drive one compare, then check in the cycle after the capturing edge
    task automatic apply(input string tag, input logic [63:0] a, input logic [63:0] b,
                         input logic dbl, input logic uc, input logic lg);
        logic [31:0] me;
        logic ie;
        model(a, b, dbl, uc, lg, me, ie);
        @(negedge clk);
        opa_i = a; opb_i = b; dbl_i = dbl; ucmp_i = uc; legacy_i = lg; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(tag, mask_o, me, invalid_o, ie, done_o, 1'b1);
    endtask

    function automatic logic [63:0] pick(input int cls, input logic dbl, input logic [63:0] other);
        logic [63:0] r;
        logic s;
        r = {$urandom, $urandom};
        s = r[7];
        if (dbl) begin
            case (cls)
                0: return {s, 63'd0};
                1: return {s, 11'h7FF, 52'd0};
                2: return {s, 11'h7FF, 1'b1, r[50:0]};
                3: return {s, 11'h7FF, 1'b0, r[50:1], 1'b1};
                4: return other;
                5: return {~other[63], other[62:0]};
                6: return {s, 11'd0, r[51:0]};
                default: return (r[62:52] == 11'h7FF) ? {r[63], 1'b0, r[61:0]} : r;
            endcase
        end else begin
            case (cls)
                0: return {r[63:32], s, 31'd0};
                1: return {r[63:32], s, 8'hFF, 23'd0};
                2: return {r[63:32], s, 8'hFF, 1'b1, r[21:0]};
                3: return {r[63:32], s, 8'hFF, 1'b0, r[21:1], 1'b1};
                4: return {r[63:32], other[31:0]};
                5: return {r[63:32], ~other[31], other[30:0]};
                6: return {r[63:32], s, 8'd0, r[22:0]};
                default: return (r[30:23] == 8'hFF) ? {r[63:31], 1'b0, r[29:0]} : r;
            endcase
        end
    endfunction

    initial begin
        #(4 * 150000);
        if (!ended) begin
            ended = 1;
            n_err++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] held_m;
        logic        held_i;
        void'($urandom(32'd20240611));
        rst = 1'b1; start_i = 1'b0; dbl_i = 1'b0; ucmp_i = 1'b0; legacy_i = 1'b0;
        opa_i = '0; opb_i = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", mask_o, 32'd0, invalid_o, 1'b0, done_o, 1'b0);
        rst = 1'b0;

        // R5 and R6: zeros of both signs equal, infinities ordered
        apply("R6", 64'h8000000000000000, 64'h0, 1'b1, 1'b0, 1'b0);
        apply("R6", 64'h0000000080000000, 64'h0, 1'b0, 1'b0, 1'b0);
        apply("R6", 64'hFFF0000000000000, 64'h7FF0000000000000, 1'b1, 1'b0, 1'b0);
        apply("R5", 64'h3FF0000000000000, 64'h4000000000000000, 1'b1, 1'b0, 1'b0);
        apply("R5", 64'hC000000000000000, 64'hBFF0000000000000, 1'b1, 1'b0, 1'b0);
        // R3 and R4: NaN handling and flag priority
        apply("R3", 64'h7FF8000000000000, 64'h0, 1'b1, 1'b0, 1'b0);
        apply("R4", 64'h000000007FC00000, 64'h000000007F800001, 1'b0, 1'b1, 1'b0);
        apply("R4", 64'h000000007F800001, 64'h000000007FC00000, 1'b0, 1'b1, 1'b0);
        apply("R4", 64'h3F80000000000000, 64'h7FF0000000000001, 1'b1, 1'b1, 1'b0);
        // R7: legacy clears the extended predicates
        apply("R7", 64'h0000000040000000, 64'h000000003F800000, 1'b0, 1'b0, 1'b1);
        apply("R7", 64'h7FF4000000000000, 64'h0, 1'b1, 1'b0, 1'b1);
        // R8: negative b leaves the range bits clear
        apply("R8", 64'h0000000000000000, 64'h00000000BF800000, 1'b0, 1'b0, 1'b0);
        // R9: each range outcome
        apply("R9", 64'h3FE0000000000000, 64'h3FF0000000000000, 1'b1, 1'b0, 1'b0);
        apply("R9", 64'hBFE0000000000000, 64'h3FF0000000000000, 1'b1, 1'b0, 1'b0);
        apply("R9", 64'h4000000000000000, 64'h3FF0000000000000, 1'b1, 1'b0, 1'b0);
        apply("R9", 64'h8000000000000000, 64'h3FF0000000000000, 1'b1, 1'b0, 1'b0);
        apply("R9", 64'h3FF0000000000000, 64'h3FF0000000000000, 1'b1, 1'b0, 1'b0);
        // R11: upper garbage ignored in single precision
        apply("R11", 64'hFFF8000000000000 | 64'h3F800000, 64'h7FF00000_40000000, 1'b0, 1'b0, 1'b0);

        // R2: done is one cycle and results hold without a strobe
        held_m = mask_o; held_i = invalid_o;
        @(negedge clk);
        opa_i = 64'h7FF8000000000001; opb_i = 64'h1; dbl_i = 1'b1;
        @(negedge clk);
        check("R2", mask_o, held_m, invalid_o, held_i, done_o, 1'b0);

        for (int k = 0; k < 3000; k++) begin
            logic        d;
            logic [63:0] a, b;
            d = $urandom_range(0, 1) != 0;
            a = pick($urandom_range(0, 9), d, 64'd0);
            b = pick($urandom_range(0, 9), d, a);
            // R5 with R3, R9 and R10 covered by the model across random classes
            apply("R5", a, b, d, $urandom_range(0, 1) != 0, $urandom_range(0, 3) == 0);
        end

        // R1: reset in the middle of operation
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1", mask_o, 32'd0, invalid_o, 1'b0, done_o, 1'b0);
        rst = 1'b0;

        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end
endmodule